// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block is the host side of a PS/2 link. A small register interface (write strobe, read strobe, address, data) faces the processor. Two open-drain lines face the device: each line is modelled as an output enable that pulls it low, plus a sampled input that carries the wired level. The device always generates the clock. The host only holds the clock low, and it does so only to ask for a transfer.

In the receive direction, the block collects the 11-bit frames that the device clocks out. It places each byte in a holding register and raises a ready flag. It also flags parity mismatches, and it flags bytes that arrive before the previous one was read. In the transmit direction, a write to the transmit register starts the transfer. The block holds the clock low for a number of module cycles set by a prescale register, then presents the start bit and releases the clock. After that it shifts the byte, the parity bit and the stop bit out under the device's clock. Starting a transmission abandons any frame that is partly received. A bit-period watchdog returns a stalled frame to idle.

Top module: `ps2_host_port`

## Requirements
- R1: After reset both output enables are 0 and the status register (addr 4) and the control register (addr 0) both read 0.
- R2: With receive on (control bit 0 = 1), an 11-bit frame is accepted on falling device clock edges. The frame is a start 0, eight data bits least significant first, odd parity, and a stop 1. The byte is then readable at addr 2, and status bit 0 (ready) is set.
- R3: With transmit on (control bit 1 = 1), a write to addr 3 holds the clock enable high for exactly P module cycles, where P is the prescale register at addr 1 (P = 0 behaves as 1).
- R4: When the clock enable drops, the data enable is already 1 (start bit low). On falls 1 to 8 the host presents data bits 0 to 7. On fall 9 it presents odd parity, and on fall 10 it releases data for the stop bit. After fall 11 both enables are 0.
- R5: With control bit 0 = 0, the receiver accepts nothing, and a frame in progress is dropped.
- R6: A received byte whose parity bit does not make the total count of ones odd sets status bit 1 (parity error).
- R7: A byte completing while ready is still set and not being read sets status bit 2 (overrun), and the new byte replaces the held one.
- R8: Reading addr 2 clears ready, and reading addr 4 clears parity error and overrun. A flag set by a byte completing in the same cycle wins over the clear.
- R9: A write to addr 3 while control bit 1 = 0 starts nothing: the clock enable stays 0.
- R10: Starting a transmission discards any partly received frame. The next full frame is received intact.
- R11: If no falling clock edge arrives within the watchdog limit during a frame, the frame returns to idle, so the next frame is received intact.
- R12: The control register (addr 0, bits 1:0) and the prescale register (addr 1) read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for reg_addr (combinational) |
| ps2_clk_in | input | 1 | Sampled level of the clock line |
| ps2_dat_in | input | 1 | Sampled level of the data line |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the data line low |

## Verification
A read of the receive holding register can fall in the same cycle as the completion of a new byte. The outcome decides whether the ready and overrun flags are correct. The bench first leaves an old byte unread. It then sends a second frame and issues the read at a sweep of offsets after the last falling clock edge, so that one offset lands on the completion cycle. Each outcome is judged by what the read returned. If it returned the old byte, the new byte must still be ready with no overrun. If it returned the new byte, ready must be clear and overrun set.

// File: rtl/ps2_host_pkg.sv
package ps2_host_pkg;

   localparam int ADDR_W     = 3;
   localparam int FRAME_BITS = 11;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL  = 3'd0,
      REG_PRESC = 3'd1,
      REG_RXD   = 3'd2,
      REG_TXD   = 3'd3,
      REG_STAT  = 3'd4
   } reg_addr_e;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_REQ   = 2'd1,
      TX_SHIFT = 2'd2
   } tx_state_e;

   function automatic logic odd_par(input logic [7:0] d);
      return ~(^d);
   endfunction

endpackage

// File: rtl/ps2_host_sync.sv
module ps2_host_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] st;

   initial begin
      assert (STAGES >= 2) else $error("sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= '1;
      else        st <= {st[STAGES-2:0], d};
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx #(
   parameter int WDOG_LIM = 200000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       abort,
   input  logic       hold,
   input  logic       fall,
   input  logic       dat,
   output logic       busy,
   output logic       done,
   output logic [7:0] byte_o,
   output logic       perr
);
   localparam int WD_W = $clog2(WDOG_LIM + 1);

   logic [3:0]      idx;
   logic [7:0]      sh;
   logic            par;
   logic [WD_W-1:0] wd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx    <= '0;
         sh     <= '0;
         par    <= 1'b0;
         wd     <= '0;
         done   <= 1'b0;
         byte_o <= '0;
         perr   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!en || abort || hold) begin
            idx <= '0;
            wd  <= '0;
         end else if (fall) begin
            wd <= '0;
            if (idx == 4'd0) begin
               if (!dat) idx <= 4'd1;
            end else if (idx <= 4'd8) begin
               sh  <= {dat, sh[7:1]};
               idx <= idx + 4'd1;
            end else if (idx == 4'd9) begin
               par <= dat;
               idx <= 4'd10;
            end else begin
               done   <= 1'b1;
               byte_o <= sh;
               perr   <= ((^{sh, par}) == 1'b0);
               idx    <= '0;
            end
         end else if (idx != 4'd0) begin
            if (wd == WD_W'(WDOG_LIM)) begin
               idx <= '0;
               wd  <= '0;
            end else begin
               wd <= wd + 1'b1;
            end
         end
      end
   end

   assign busy = (idx != 4'd0);

   a_r5_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);
   a_r11_wdog_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (wd <= WD_W'(WDOG_LIM)));
endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
   import ps2_host_pkg::*;
#(
   parameter int PRESC_W  = 16,
   parameter int WDOG_LIM = 200000,
   parameter int SETTLE   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [7:0]         data,
   input  logic [PRESC_W-1:0] presc,
   input  logic               fall,
   output logic               busy,
   output logic               clk_oe,
   output logic               dat_oe
);
   localparam int WD_W = $clog2(WDOG_LIM + 1);

   tx_state_e          state;
   logic [PRESC_W-1:0] cnt;
   logic [3:0]         idx;
   logic [8:0]         sh;
   logic [WD_W-1:0]    wd;
   logic               dat_oe_r;
   logic               fall_ok;

   assign fall_ok = fall && !(idx == 4'd0 && wd < WD_W'(SETTLE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= TX_IDLE;
         cnt      <= '0;
         idx      <= '0;
         sh       <= '0;
         wd       <= '0;
         dat_oe_r <= 1'b0;
      end else begin
         case (state)
            TX_IDLE: begin
               dat_oe_r <= 1'b0;
               if (start) begin
                  state <= TX_REQ;
                  cnt   <= '0;
                  sh    <= {odd_par(data), data};
               end
            end
            TX_REQ: begin
               if (({1'b0, cnt} + 1'b1) >= {1'b0, presc}) begin
                  state    <= TX_SHIFT;
                  idx      <= '0;
                  wd       <= '0;
                  dat_oe_r <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            TX_SHIFT: begin
               if (fall_ok) begin
                  wd  <= '0;
                  idx <= idx + 4'd1;
                  if (idx <= 4'd8) begin
                     dat_oe_r <= ~sh[0];
                     sh       <= {1'b0, sh[8:1]};
                  end else if (idx == 4'd9) begin
                     dat_oe_r <= 1'b0;
                  end else begin
                     state    <= TX_IDLE;
                     dat_oe_r <= 1'b0;
                  end
               end else if (wd == WD_W'(WDOG_LIM)) begin
                  state    <= TX_IDLE;
                  dat_oe_r <= 1'b0;
               end else begin
                  wd <= wd + 1'b1;
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   assign busy   = (state != TX_IDLE);
   assign clk_oe = (state == TX_REQ);
   assign dat_oe = dat_oe_r;

   a_r4_start_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_oe) |-> dat_oe);
   a_r3_req_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_oe) |-> !dat_oe);
endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port
   import ps2_host_pkg::*;
#(
   parameter int PRESC_W     = 16,
   parameter int REG_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int WDOG_LIM    = 200000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [2:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             ps2_clk_in,
   input  logic             ps2_dat_in,
   output logic             ps2_clk_oe,
   output logic             ps2_dat_oe
);
   localparam int SETTLE = SYNC_STAGES + 2;

   initial begin
      assert (REG_W >= PRESC_W && REG_W >= 8) else $error("register width too small");
      assert (PRESC_W >= 2) else $error("prescale width too small");
   end

   logic               rxen, txen;
   logic [PRESC_W-1:0] presc;
   logic [7:0]         rhr, thr;
   logic               rdy, perr_f, ovr_f;
   logic               s_clk, s_dat, clk_q, fall;
   logic               rx_busy, rx_done, rx_perr;
   logic [7:0]         rx_byte;
   logic               tx_busy, tx_start;
   logic               rd_rhr, rd_st;

   ps2_host_sync #(.STAGES(SYNC_STAGES), .W(2)) sync_i (
      .clk(clk), .rst_n(rst_n),
      .d({ps2_clk_in, ps2_dat_in}), .q({s_clk, s_dat}));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_q <= 1'b1;
      else        clk_q <= s_clk;
   end
   assign fall = clk_q & ~s_clk;

   assign tx_start = reg_wr && (reg_addr == REG_TXD) && txen && !tx_busy;
   assign rd_rhr   = reg_rd && (reg_addr == REG_RXD);
   assign rd_st    = reg_rd && (reg_addr == REG_STAT);

   ps2_host_rx #(.WDOG_LIM(WDOG_LIM)) rx_i (
      .clk(clk), .rst_n(rst_n), .en(rxen), .abort(tx_start), .hold(tx_busy),
      .fall(fall), .dat(s_dat), .busy(rx_busy), .done(rx_done),
      .byte_o(rx_byte), .perr(rx_perr));

   ps2_host_tx #(.PRESC_W(PRESC_W), .WDOG_LIM(WDOG_LIM), .SETTLE(SETTLE)) tx_i (
      .clk(clk), .rst_n(rst_n), .start(tx_start), .data(thr), .presc(presc),
      .fall(fall), .busy(tx_busy), .clk_oe(ps2_clk_oe), .dat_oe(ps2_dat_oe));

   assign thr = reg_wdata[7:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxen   <= 1'b0;
         txen   <= 1'b0;
         presc  <= '0;
         rhr    <= '0;
         rdy    <= 1'b0;
         perr_f <= 1'b0;
         ovr_f  <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == REG_CTRL) begin
            rxen <= reg_wdata[0];
            txen <= reg_wdata[1];
         end
         if (reg_wr && reg_addr == REG_PRESC) presc <= reg_wdata[PRESC_W-1:0];
         if (rd_rhr) rdy <= 1'b0;
         if (rd_st) begin
            perr_f <= 1'b0;
            ovr_f  <= 1'b0;
         end
         if (rx_done) begin
            rhr <= rx_byte;
            rdy <= 1'b1;
            if (rdy && !rd_rhr) ovr_f <= 1'b1;
            if (rx_perr) perr_f <= 1'b1;
         end
      end
   end

   always_comb begin
      case (reg_addr)
         REG_CTRL:  reg_rdata = REG_W'({txen, rxen});
         REG_PRESC: reg_rdata = REG_W'(presc);
         REG_RXD:   reg_rdata = REG_W'(rhr);
         REG_STAT:  reg_rdata = REG_W'({ovr_f, perr_f, rdy});
         default:   reg_rdata = '0;
      endcase
   end

   a_r2_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> rdy);
   a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rdy && !rd_rhr) |=> ovr_f);
   a_r10_abort_rx: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !rx_busy);
   a_r9_tx_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!txen && !tx_busy) |=> !ps2_clk_oe);
endmodule

// File: tb/ps2_host_port_tb.sv
module ps2_host_port_tb_top;
   localparam int H    = 20;
   localparam int WDOG = 300;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        ps2_clk_oe, ps2_dat_oe;
   logic        dev_clk = 1'b1, dev_dat = 1'b1;
   logic        ps2_clk_in, ps2_dat_in;
   int          n_chk = 0, n_bad = 0;
   bit          finished = 1'b0;

   assign ps2_clk_in = dev_clk & ~ps2_clk_oe;
   assign ps2_dat_in = dev_dat & ~ps2_dat_oe;

   always #2 clk = ~clk;

   ps2_host_port #(.WDOG_LIM(WDOG)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ps2_clk_in(ps2_clk_in), .ps2_dat_in(ps2_dat_in),
      .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   function automatic logic [10:0] frame(input logic [7:0] d, input logic bad);
      return {1'b1, (~^d) ^ bad, d, 1'b0};
   endfunction

   task automatic dev_bits(input logic [10:0] fr, input int n);
      for (int i = 0; i < n; i++) begin
         dev_dat = fr[i];
         repeat (H) @(negedge clk);
         dev_clk = 1'b0;
         repeat (H) @(negedge clk);
         dev_clk = 1'b1;
      end
      dev_dat = 1'b1;
      repeat (H) @(negedge clk);
   endtask

   task automatic rx_expect(input string req, input logic [7:0] d, input logic [2:0] st);
      logic [15:0] v;
      rd(3'd4, v);
      chk(req, v, {13'd0, st});
      rd(3'd2, v);
      chk(req, v, {8'd0, d});
   endtask

   // device side of a host transmission; checks R3 and R4
   task automatic tx_run(input logic [7:0] d, input int p);
      int          cnt = 0;
      logic [11:1] got;
      wr(3'd3, {8'd0, d});
      while (ps2_clk_oe) begin cnt++; @(negedge clk); end
      chk("R3 request length", cnt, (p == 0) ? 1 : p);
      chk("R4 start bit low", ps2_dat_oe, 1'b1);
      for (int i = 1; i <= 11; i++) begin
         repeat (H) @(negedge clk);
         dev_clk = 1'b0;
         if (i == 11) dev_dat = 1'b0;
         repeat (H) @(negedge clk);
         got[i] = ~ps2_dat_oe;
         dev_clk = 1'b1;
         if (i == 11) dev_dat = 1'b1;
      end
      repeat (8) @(negedge clk);
      chk("R4 data bits", got[8:1], d);
      chk("R4 odd parity", got[9], ~^d);
      chk("R4 stop released", got[10], 1'b1);
      chk("R4 lines idle", {ps2_clk_oe, ps2_dat_oe}, 2'b00);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      chk("R1 oe idle", {ps2_clk_oe, ps2_dat_oe}, 2'b00);
      rd(3'd4, v); chk("R1 status", v, 0);
      rd(3'd0, v); chk("R1 ctrl", v, 0);
   endtask

   task automatic t_regs;
      logic [15:0] v;
      wr(3'd1, 16'h1234); rd(3'd1, v); chk("R12 prescale", v, 16'h1234);
      wr(3'd0, 16'h0003); rd(3'd0, v); chk("R12 ctrl", v, 16'h0003);
   endtask

   task automatic t_rx_basic;
      wr(3'd0, 16'h0001);
      dev_bits(frame(8'hA5, 1'b0), 11); rx_expect("R2 byte A5", 8'hA5, 3'b001);
      dev_bits(frame(8'h00, 1'b0), 11); rx_expect("R2 byte 00", 8'h00, 3'b001);
      dev_bits(frame(8'hFE, 1'b0), 11); rx_expect("R2 byte FE", 8'hFE, 3'b001);
   endtask

   task automatic t_parity;
      logic [15:0] v;
      dev_bits(frame(8'h3B, 1'b1), 11);
      rx_expect("R6 parity error", 8'h3B, 3'b011);
      rd(3'd4, v); chk("R8 status read clears", v, 0);
   endtask

   task automatic t_overrun;
      logic [15:0] v;
      dev_bits(frame(8'h11, 1'b0), 11);
      dev_bits(frame(8'h22, 1'b0), 11);
      rx_expect("R7 overrun newest", 8'h22, 3'b101);
      rd(3'd4, v); chk("R8 ready cleared by data read", v, 0);
   endtask

   task automatic t_rx_off;
      logic [15:0] v;
      wr(3'd0, 16'h0000);
      dev_bits(frame(8'h77, 1'b0), 11);
      rd(3'd4, v); chk("R5 disabled ignores", v, 0);
      wr(3'd0, 16'h0001);
      dev_bits(frame(8'hC3, 1'b0), 5);
      wr(3'd0, 16'h0000);
      wr(3'd0, 16'h0001);
      dev_bits(frame(8'h99, 1'b0), 11);
      rx_expect("R5 mid-frame drop", 8'h99, 3'b001);
   endtask

   task automatic t_tx;
      wr(3'd0, 16'h0003);
      wr(3'd1, 16'd50); tx_run(8'h5A, 50);
      wr(3'd1, 16'd7);  tx_run(8'h01, 7);
      wr(3'd1, 16'd0);  tx_run(8'hF0, 0);
   endtask

   task automatic t_tx_off;
      int seen = 0;
      wr(3'd0, 16'h0001);
      wr(3'd3, 16'h00AA);
      for (int i = 0; i < 40; i++) begin
         if (ps2_clk_oe) seen++;
         @(negedge clk);
      end
      chk("R9 transmit disabled", seen, 0);
   endtask

   task automatic t_abort;
      logic [15:0] v;
      wr(3'd0, 16'h0003);
      wr(3'd1, 16'd30);
      dev_bits(frame(8'h81, 1'b0), 5);
      tx_run(8'h42, 30);
      rd(3'd4, v); chk("R10 aborted rx", v, 0);
      dev_bits(frame(8'h66, 1'b0), 11);
      rx_expect("R10 next frame", 8'h66, 3'b001);
   endtask

   task automatic t_wdog;
      dev_bits(frame(8'h55, 1'b0), 4);
      repeat (WDOG + 60) @(negedge clk);
      dev_bits(frame(8'h3C, 1'b0), 11);
      rx_expect("R11 watchdog recovery", 8'h3C, 3'b001);
   endtask

   // R8 collision: data read swept across the byte-completion cycle
   task automatic t_collide;
      logic [15:0]  v, got;
      logic [10:0]  fr;
      wr(3'd0, 16'h0001);
      for (int k = 0; k < 10; k++) begin
         dev_bits(frame(8'h10, 1'b0), 11);
         fr = frame(8'h20 + 8'(k), 1'b0);
         dev_bits(fr, 10);
         dev_dat = fr[10];
         repeat (H) @(negedge clk);
         dev_clk = 1'b0;
         repeat (k) @(negedge clk);
         rd(3'd2, got);
         repeat (H) @(negedge clk);
         dev_clk = 1'b1;
         dev_dat = 1'b1;
         repeat (H) @(negedge clk);
         rd(3'd4, v);
         if (got[7:0] == 8'h10) chk("R8 read before/with completion", v[2:0], 3'b001);
         else begin
            chk("R8 read got new byte", got, 16'h20 + 16'(k));
            chk("R8 read after completion", v[2:0], 3'b100);
         end
         rd(3'd2, v);
         rd(3'd4, v);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      t_regs;
      t_rx_basic;
      t_parity;
      t_overrun;
      t_rx_off;
      t_tx;
      t_tx_off;
      t_abort;
      t_wdog;
      t_collide;
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule